// File: doc/BRIEF.md
# M/N Clock Divider Coefficient Search Engine

This block is a sequential search engine for a fractional clock generator whose output rate is the parent rate multiplied by M and divided by N. Software or a sequencer gives it a 32-bit parent rate and a 32-bit target rate, pulses `start`, and waits for `done`. The engine returns the M/N pair it chose, the rate that pair actually produces, and an error flag.

The search runs in three phases. First it checks that the request is legal. Next it tries a single integer division of the parent by the target. When that division leaves no remainder, the answer is M=1 and N is the quotient. When it leaves a remainder, the engine walks M from the top of its range down to 1. For each M, N is the quotient of parent·M by the target, and the remainder measures the error. The engine keeps the best legal pair it has seen and stops as soon as a pair gives an exact result. Only one restoring divider exists. It produces one quotient bit per clock. The product parent·M is not multiplied afresh for each candidate: it starts at parent·511 and is reduced by the parent rate at each step.

Top module: `mn_coef_search`

## Requirements
- R1: A request with a target rate of zero, or with a parent rate below twice the target rate, finishes with errOut=1 and mOut, nOut and rateOut all zero.
- R2: When the parent divides exactly by the target, the result is M=1 and N equal to the quotient, with no sweep. If that quotient exceeds 1048575, the request finishes with errOut=1 and zero outputs.
- R3: Otherwise the engine evaluates M = 511, 510, …, 1. For each M, N = floor(parent·M / target). A pair is legal only when 2·M ≤ N ≤ 1048575.
- R4: A legal pair with zero remainder ends the search at once and is the result. It is therefore the exact pair with the largest M.
- R5: Among legal pairs with non-zero remainder, the result has the strictly smallest remainder. On a tie, the larger M wins.
- R6: When no pair is legal, the engine finishes with errOut=1 and mOut, nOut and rateOut all zero.
- R7: On success, rateOut = floor(parent·M / N) for the chosen pair and errOut=0.
- R8: `start` is accepted only while busy is low. The inputs are captured at acceptance, and a start pulse while busy has no effect. `done` is a one-cycle pulse, raised with busy already low. The outputs change only at done and hold until the next done.
- R9: After reset, busy, done, errOut, mOut, nOut and rateOut are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search with the current rate inputs |
| parentRate | input | 32 | Parent clock rate |
| reqRate | input | 32 | Requested output rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| mOut | output | 9 | Chosen multiplier M |
| nOut | output | 20 | Chosen divisor N |
| rateOut | output | 32 | Achieved rate parent·M/N |
| errOut | output | 1 | No legal pair, or illegal request |

## Verification
Some properties are checked on every cycle. Each successful result satisfies M ≥ 1 and N ≥ 2M. Each failed result reports zero coefficients. The outputs move only together with done, and done never lasts two cycles. The tracked best remainder never grows within a sweep, and the candidate M holds steady while a division runs. Other behaviour can be shown only by the bench's scenarios, which compare results against a reference search in the bench: which pair wins on a tie, where an exact hit cuts the sweep short, the exact shortcut and its N-range limit, the failed full sweep, and the fact that a start pulse during a search is ignored.

// File: rtl/mn_coef_pkg.sv
package mn_coef_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadArgs;
    logic loadShort;
    logic setShort;
    logic initSweep;
    logic loadCand;
    logic evalCand;
    logic nextCand;
    logic loadRate;
    logic finish;
    logic fail;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic divIdle;
    logic argBad;
    logic remZero;
    logic quoFitsN;
    logic candValid;
    logic candExact;
    logic candLast;
    logic haveBest;
  } dpStatus_t;
endpackage

// File: rtl/mn_coef_dp.sv
module mn_coef_dp
  import mn_coef_pkg::*;
#(
  parameter int PW = 32,
  parameter int MW = 9,
  parameter int NW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PW-1:0] parentRate,
  input  logic [PW-1:0] reqRate,
  input  ctrlStrobe_t   st,
  output dpStatus_t     stat,
  output logic [MW-1:0] mOut,
  output logic [NW-1:0] nOut,
  output logic [PW-1:0] rateOut,
  output logic          errOut
);
  localparam int DW = PW + MW;
  localparam int CW = $clog2(DW + 1);
  localparam logic [MW-1:0] M_TOP = {MW{1'b1}};
  localparam logic [DW-1:0] N_LIMIT = DW'((64'd1 << NW) - 64'd1);

  logic [PW-1:0] pReg, rReg;
  logic [DW-1:0] pExt, prodReg, initProd, twoM;
  logic [MW-1:0] candM;
  logic [DW-1:0] dvdReg, dvdLoad;
  logic [PW-1:0] remReg, dvsReg, dvsLoad;
  logic [CW-1:0] cnt;
  logic [PW:0]   shifted, diffS;
  logic          fitsDiv, anyLoad, candValid;
  logic [MW-1:0] bestM;
  logic [NW-1:0] bestN;
  logic [DW-1:0] bestProd;
  logic [PW-1:0] bestErr;
  logic          haveBest;

  assign pExt     = {{MW{1'b0}}, pReg};
  assign initProd = (pExt << MW) - pExt;
  assign twoM     = DW'({candM, 1'b0});

  // restoring divider, one quotient bit per clock
  assign shifted = {remReg, dvdReg[DW-1]};
  assign fitsDiv = shifted >= {1'b0, dvsReg};
  assign diffS   = shifted - {1'b0, dvsReg};
  assign anyLoad = st.loadShort | st.loadCand | st.loadRate;

  always_comb begin
    dvdLoad = pExt;
    dvsLoad = rReg;
    if (st.loadCand) dvdLoad = prodReg;
    if (st.loadRate) begin
      dvdLoad = bestProd;
      dvsLoad = {{(PW-NW){1'b0}}, bestN};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvdReg <= '0;
      dvsReg <= '0;
      remReg <= '0;
      cnt    <= '0;
    end else if (anyLoad) begin
      dvdReg <= dvdLoad;
      dvsReg <= dvsLoad;
      remReg <= '0;
      cnt    <= CW'(DW);
    end else if (cnt != '0) begin
      remReg <= fitsDiv ? diffS[PW-1:0] : shifted[PW-1:0];
      dvdReg <= {dvdReg[DW-2:0], fitsDiv};
      cnt    <= cnt - 1'b1;
    end
  end

  assign candValid = (dvdReg <= N_LIMIT) && (dvdReg >= twoM);

  // arguments, candidate and best tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pReg     <= '0;
      rReg     <= '0;
      candM    <= '0;
      prodReg  <= '0;
      bestM    <= '0;
      bestN    <= '0;
      bestProd <= '0;
      bestErr  <= '0;
      haveBest <= 1'b0;
    end else begin
      if (st.loadArgs) begin
        pReg     <= parentRate;
        rReg     <= reqRate;
        haveBest <= 1'b0;
      end
      if (st.setShort) begin
        bestM    <= MW'(1);
        bestN    <= dvdReg[NW-1:0];
        bestProd <= pExt;
        haveBest <= 1'b1;
      end
      if (st.initSweep) begin
        candM    <= M_TOP;
        prodReg  <= initProd;
        bestErr  <= rReg;
        haveBest <= 1'b0;
      end
      if (st.evalCand && candValid && (remReg < bestErr)) begin
        bestM    <= candM;
        bestN    <= dvdReg[NW-1:0];
        bestProd <= prodReg;
        bestErr  <= remReg;
        haveBest <= 1'b1;
      end
      if (st.nextCand) begin
        candM   <= candM - 1'b1;
        prodReg <= prodReg - pExt;
      end
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mOut    <= '0;
      nOut    <= '0;
      rateOut <= '0;
      errOut  <= 1'b0;
    end else if (st.finish) begin
      mOut    <= bestM;
      nOut    <= bestN;
      rateOut <= dvdReg[PW-1:0];
      errOut  <= 1'b0;
    end else if (st.fail) begin
      mOut    <= '0;
      nOut    <= '0;
      rateOut <= '0;
      errOut  <= 1'b1;
    end
  end

  assign stat.divIdle   = (cnt == '0);
  assign stat.argBad    = (rReg == '0) || ({1'b0, pReg} < {rReg, 1'b0});
  assign stat.remZero   = (remReg == '0);
  assign stat.quoFitsN  = (dvdReg <= N_LIMIT);
  assign stat.candValid = candValid;
  assign stat.candExact = candValid && (remReg == '0);
  assign stat.candLast  = (candM == MW'(1));
  assign stat.haveBest  = haveBest;

  // candidate M must not move while its division runs (R3)
  assert_cand_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> $stable(candM));

  // best remainder only shrinks between sweep starts (R5)
  assert_best_shrinks_R5: assert property (@(posedge clk) disable iff (!rstN)
    !st.initSweep |=> (bestErr <= $past(bestErr)));
endmodule

// File: rtl/mn_coef_ctrl.sv
module mn_coef_ctrl
  import mn_coef_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   stat,
  output ctrlStrobe_t st,
  output logic        busy,
  output logic        done
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_SWAIT, S_CLOAD, S_CWAIT, S_RLOAD, S_RWAIT
  } state_t;

  state_t state, stateNext;
  logic   doneSet;

  always_comb begin
    st        = '0;
    stateNext = state;
    doneSet   = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        st.loadArgs = 1'b1;
        stateNext   = S_CHECK;
      end
      S_CHECK: if (stat.argBad) begin
        st.fail = 1'b1; doneSet = 1'b1; stateNext = S_IDLE;
      end else begin
        st.loadShort = 1'b1; stateNext = S_SWAIT;
      end
      S_SWAIT: if (stat.divIdle) begin
        if (stat.remZero && stat.quoFitsN) begin
          st.setShort = 1'b1; stateNext = S_RLOAD;
        end else if (stat.remZero) begin
          st.fail = 1'b1; doneSet = 1'b1; stateNext = S_IDLE;
        end else begin
          st.initSweep = 1'b1; stateNext = S_CLOAD;
        end
      end
      S_CLOAD: begin
        st.loadCand = 1'b1; stateNext = S_CWAIT;
      end
      S_CWAIT: if (stat.divIdle) begin
        st.evalCand = 1'b1;
        if (stat.candExact) stateNext = S_RLOAD;
        else if (!stat.candLast) begin
          st.nextCand = 1'b1; stateNext = S_CLOAD;
        end else if (stat.haveBest || stat.candValid) stateNext = S_RLOAD;
        else begin
          st.fail = 1'b1; doneSet = 1'b1; stateNext = S_IDLE;
        end
      end
      S_RLOAD: begin
        st.loadRate = 1'b1; stateNext = S_RWAIT;
      end
      S_RWAIT: if (stat.divIdle) begin
        st.finish = 1'b1; doneSet = 1'b1; stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneSet;
    end
  end

  assign busy = (state != S_IDLE);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/mn_coef_search.sv
module mn_coef_search
  import mn_coef_pkg::*;
#(
  parameter int PW = 32,
  parameter int MW = 9,
  parameter int NW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [PW-1:0] parentRate,
  input  logic [PW-1:0] reqRate,
  output logic          busy,
  output logic          done,
  output logic [MW-1:0] mOut,
  output logic [NW-1:0] nOut,
  output logic [PW-1:0] rateOut,
  output logic          errOut
);
  ctrlStrobe_t st;
  dpStatus_t   stat;

  mn_coef_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat),
    .st(st), .busy(busy), .done(done)
  );

  mn_coef_dp #(.PW(PW), .MW(MW), .NW(NW)) uDp (
    .clk(clk), .rstN(rstN), .parentRate(parentRate), .reqRate(reqRate),
    .st(st), .stat(stat), .mOut(mOut), .nOut(nOut),
    .rateOut(rateOut), .errOut(errOut)
  );

  // a successful result always respects M >= 1 and N >= 2M (R3)
  assert_legal_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !errOut) |-> ((mOut != '0) &&
      ((NW+1)'(nOut) >= (NW+1)'({mOut, 1'b0}))));

  // a failed result carries zero coefficients (R1, R6)
  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && errOut) |-> (mOut == '0 && nOut == '0 && rateOut == '0));

  // outputs move only together with done (R8)
  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(mOut) && $stable(nOut) && $stable(rateOut) && $stable(errOut)));
endmodule

// File: tb/sim_mn_coef_search.sv
module sim_mn_coef_search;
  localparam longint unsigned NMAX = 1048575;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] parentRate = '0;
  logic [31:0] reqRate = '0;
  logic        busy, done, errOut;
  logic [8:0]  mOut;
  logic [19:0] nOut;
  logic [31:0] rateOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mn_coef_search u0 (
    .clk(clk), .rstN(rstN), .start(start), .parentRate(parentRate),
    .reqRate(reqRate), .busy(busy), .done(done), .mOut(mOut),
    .nOut(nOut), .rateOut(rateOut), .errOut(errOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void refCalc(input longint unsigned p, input longint unsigned r,
                                  output longint unsigned m, output longint unsigned n,
                                  output longint unsigned rate, output bit e);
    longint unsigned bestErr;
    bit found;
    m = 0; n = 0; rate = 0; e = 1'b1; found = 1'b0;
    if (r == 0 || p < 2 * r) return;
    if (p % r == 0) begin
      if (p / r > NMAX) return;
      m = 1; n = p / r;
      found = 1'b1;
    end else begin
      bestErr = r;
      for (longint unsigned cm = 511; cm >= 1; cm--) begin
        longint unsigned cn, cr;
        cn = (p * cm) / r;
        cr = (p * cm) % r;
        if (cn < 2 * cm || cn > NMAX) continue;
        if (cr == 0) begin
          m = cm; n = cn; found = 1'b1;
          break;
        end
        if (cr < bestErr) begin
          m = cm; n = cn; bestErr = cr; found = 1'b1;
        end
      end
    end
    if (found) begin
      e = 1'b0;
      rate = (p * m) / n;
    end
  endfunction

  task automatic runCase(input logic [31:0] p, input logic [31:0] r,
                         input string req, input bit midStart);
    longint unsigned em, en, erate;
    bit ee;
    int waitCnt;
    logic [8:0] hm;
    logic [19:0] hn;
    logic [31:0] hr;
    logic he;
    refCalc(longint'(p), longint'(r), em, en, erate, ee);
    @(negedge clk);
    parentRate = p; reqRate = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", longint'(busy), 1);
    if (midStart) begin
      repeat (5) @(negedge clk);
      parentRate = 32'd600; reqRate = 32'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 30000) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(done == 1'b1, "R8", "done seen", longint'(done), 1);
    chk(busy == 1'b0, "R8", "busy low at done", longint'(busy), 0);
    chk(errOut == ee, req, "err", longint'(errOut), longint'(ee));
    chk(longint'(mOut) == em, req, "M", longint'(mOut), em);
    chk(longint'(nOut) == en, req, "N", longint'(nOut), en);
    chk(longint'(rateOut) == erate, "R7", "rate", longint'(rateOut), erate);
    hm = mOut; hn = nOut; hr = rateOut; he = errOut;
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", longint'(done), 0);
    repeat (3) @(negedge clk);
    chk(mOut == hm && nOut == hn && rateOut == hr && errOut == he, "R8",
        "outputs held", longint'(mOut), longint'(hm));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 199000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy == 0 && done == 0, "R9", "busy/done at reset", longint'({busy, done}), 0);
    chk(mOut == 0 && nOut == 0 && rateOut == 0 && errOut == 0, "R9",
        "outputs at reset", longint'(mOut) + longint'(nOut) + longint'(rateOut), 0);
    rstN = 1'b1;
    runCase(32'd1000, 32'd0, "R1", 1'b0);
    runCase(32'd100, 32'd51, "R1", 1'b0);
    runCase(32'd100, 32'd50, "R2", 1'b0);
    runCase(32'd1048575, 32'd1, "R2", 1'b0);
    runCase(32'd2097152, 32'd2, "R2", 1'b0);
    runCase(32'd1000, 32'd3, "R4", 1'b0);
    runCase(32'd4000000001, 32'd2, "R6", 1'b0);
    runCase(32'd1000000007, 32'd1000, "R3", 1'b1);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] p, r;
      p = $urandom | 32'h0000_1000;
      if (i < 2) r = (p >> (4 + ($urandom % 12))) + ($urandom % 5) + 1;
      else r = 32'd1 + ($urandom % 997);
      runCase(p, r, "R5", 1'b0);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule